// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block is the interrupt section of a UART register file. It keeps a raw status vector, in which events from the receive FIFO, the transmitter, the receive-timeout counter, the modem-status logic and the error detector set bits. It also keeps a mask register that selects which of those bits may reach the interrupt outputs. Software reads the raw and the masked status and acknowledges events through a write-one-to-clear register. A write to the transmit data address also raises the transmit status bit.

Six registered interrupt lines leave the block. Each line is a fixed OR over one group of the masked status, and one combined line covers all groups. Counting the receive timeout and detecting errors are done elsewhere. This block only records the pulses it is given.

Status bit layout with default parameters (MS_W = 4, ERR_W = 4, 11 bits): bits [3:0] modem status, bit 4 receive, bit 5 transmit, bit 6 receive timeout, bits [10:7] error. Register word addresses: 0 mask (read/write), 1 raw status (read only), 2 masked status (read only), 3 clear (write only), 4 transmit data (write only as seen by this block).

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask register, the raw status and all six outputs are 0.
- R2: Writing address 0 loads the mask from bus_wdata[10:0], and reading address 0 returns it. Reading address 2 returns raw status AND mask.
- R3: Writing address 3 clears every raw bit whose bus_wdata bit is 1 and leaves the other bits as they were. Reading address 3 returns 0.
- R4: Writes to address 1 (raw) and address 2 (masked) change neither the raw status nor the mask.
- R5: A 1 on an event input in a cycle sets its raw bit at that clock edge. Positions: ev_ms[i] sets bit i, ev_rx sets bit 4, ev_tx sets bit 5, ev_rt sets bit 6, ev_err[j] sets bit 7+j. Reading address 1 returns the raw status.
- R6: A bus write to address 4 sets raw bit 5 (transmit), whatever the written data.
- R7: When a set event and a clear write target the same bit in one cycle, the bit ends up set.
- R8: irq_out[0] (combined) is 1 when any masked status bit is 1.
- R9: irq_out[1] receive (bit 4), irq_out[2] transmit (bit 5), irq_out[3] timeout (bit 6), irq_out[4] modem (bits 3:0) and irq_out[5] error (bits 10:7) are each 1 when any masked bit of their own group is 1.
- R10: The outputs are registered. They reflect the raw and mask values held after the previous clock edge, so they change one cycle after the state changes.
- R11: Reads of addresses 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| ev_rx | input | 1 | Receive FIFO level event pulse |
| ev_tx | input | 1 | Transmitter event pulse |
| ev_rt | input | 1 | Receive timeout event pulse |
| ev_ms | input | 4 | Modem-status change event pulses |
| ev_err | input | 4 | Receive error event pulses |
| irq_out | output | 6 | Lines: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error |

## Verification
On every cycle the assertions check four things. Set events always land in the raw status, even when a clear write targets the same bit. Clear writes remove the acknowledged bits. The mask holds unless it is written, and status-address writes do not disturb the raw vector. The combined line agrees with the five group lines, and the clear address reads zero. Three behaviours are shown only by the bench's scenarios: which group each output follows under partial masks, the one-cycle output delay, and the values read back at each address, all compared against a reference model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  // register word addresses
  localparam int unsigned ADR_MASK = 0;
  localparam int unsigned ADR_RAW  = 1;
  localparam int unsigned ADR_MSKD = 2;
  localparam int unsigned ADR_CLR  = 3;
  localparam int unsigned ADR_TXD  = 4;

  // output line order
  localparam int NUM_LINES = 6;
  localparam int LINE_ALL  = 0;
  localparam int LINE_RX   = 1;
  localparam int LINE_TX   = 2;
  localparam int LINE_RT   = 3;
  localparam int LINE_MS   = 4;
  localparam int LINE_ERR  = 5;

  function automatic int rx_pos(int ms_w);
    return ms_w;
  endfunction

  function automatic int tx_pos(int ms_w);
    return ms_w + 1;
  endfunction

  function automatic int rt_pos(int ms_w);
    return ms_w + 2;
  endfunction

  function automatic int err_lo(int ms_w);
    return ms_w + 3;
  endfunction

  // group selection mask of one output line over the status vector
  function automatic logic [63:0] line_mask(int line, int ms_w, int err_w);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 64; b++) begin
      logic in_ms, in_rx, in_tx, in_rt, in_err;
      in_ms  = (b < ms_w);
      in_rx  = (b == rx_pos(ms_w));
      in_tx  = (b == tx_pos(ms_w));
      in_rt  = (b == rt_pos(ms_w));
      in_err = (b >= err_lo(ms_w)) && (b < err_lo(ms_w) + err_w);
      case (line)
        LINE_ALL: m[b] = in_ms | in_rx | in_tx | in_rt | in_err;
        LINE_RX:  m[b] = in_rx;
        LINE_TX:  m[b] = in_tx;
        LINE_RT:  m[b] = in_rt;
        LINE_MS:  m[b] = in_ms;
        default:  m[b] = in_err;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/uirq_status_reg.sv
module uirq_status_reg #(
  parameter int NSRC   = 11,
  parameter int TX_BIT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_set,
  input  logic            tx_set,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] mask_q
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] tx_vec;

  always_comb begin
    tx_vec = '0;
    tx_vec[TX_BIT] = tx_set;
  end

  assign set_vec = ev_set | tx_vec;
  assign clr_vec = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_q & $past(clr_bits & ~set_vec)) == '0));

  a_r6_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> raw_q[TX_BIT]);

  a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/uirq_bus_if.sv
module uirq_bus_if
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int NSRC   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   raw_q,
  input  logic [NSRC-1:0]   mask_q,
  output logic              mask_we,
  output logic [NSRC-1:0]   mask_wdata,
  output logic              clr_we,
  output logic [NSRC-1:0]   clr_bits,
  output logic              tx_set,
  output logic [DATA_W-1:0] bus_rdata
);
  logic hit_mask, hit_raw, hit_mskd, hit_clr, hit_txd;

  assign hit_mask = (bus_addr == ADDR_W'(ADR_MASK));
  assign hit_raw  = (bus_addr == ADDR_W'(ADR_RAW));
  assign hit_mskd = (bus_addr == ADDR_W'(ADR_MSKD));
  assign hit_clr  = (bus_addr == ADDR_W'(ADR_CLR));
  assign hit_txd  = (bus_addr == ADDR_W'(ADR_TXD));

  assign mask_we    = bus_wr & hit_mask;
  assign clr_we     = bus_wr & hit_clr;
  assign tx_set     = bus_wr & hit_txd;
  assign mask_wdata = bus_wdata[NSRC-1:0];
  assign clr_bits   = bus_wdata[NSRC-1:0];

  always_comb begin
    bus_rdata = '0;
    if (hit_mask)      bus_rdata[NSRC-1:0] = mask_q;
    else if (hit_raw)  bus_rdata[NSRC-1:0] = raw_q;
    else if (hit_mskd) bus_rdata[NSRC-1:0] = raw_q & mask_q;
  end

  a_r3_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |-> (bus_rdata == '0));

  a_r4_status_wr_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (hit_raw || hit_mskd)) |-> !(mask_we || clr_we || tx_set));
endmodule

// File: rtl/uirq_router.sv
module uirq_router
  import uirq_pkg::*;
#(
  parameter int MS_W  = 4,
  parameter int ERR_W = 4,
  parameter int NSRC  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      raw_q,
  input  logic [NSRC-1:0]      mask_q,
  output logic [NUM_LINES-1:0] irq_q
);
  logic [NSRC-1:0] active;
  assign active = raw_q & mask_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [63:0] LM = line_mask(g, MS_W, ERR_W);
    logic [NSRC-1:0] sel;
    assign sel = LM[NSRC-1:0];
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= |(active & sel);
    end
  end

  a_r8_combined_union: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q[LINE_ALL] == (|irq_q[NUM_LINES-1:1]));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int MS_W   = 4,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rx,
  input  logic              ev_tx,
  input  logic              ev_rt,
  input  logic [MS_W-1:0]   ev_ms,
  input  logic [ERR_W-1:0]  ev_err,
  output logic [5:0]        irq_out
);
  localparam int NSRC = 3 + MS_W + ERR_W;

  logic [NSRC-1:0] ev_vec, raw_q, mask_q, mask_wdata, clr_bits;
  logic            mask_we, clr_we, tx_set;
  logic            status_wr;

  assign ev_vec = {ev_err, ev_rt, ev_tx, ev_rx, ev_ms};
  assign status_wr = bus_wr && (bus_addr == ADDR_W'(ADR_RAW) ||
                                bus_addr == ADDR_W'(ADR_MSKD));

  uirq_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw_q(raw_q), .mask_q(mask_q),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we),
    .clr_bits(clr_bits), .tx_set(tx_set), .bus_rdata(bus_rdata)
  );

  uirq_status_reg #(.NSRC(NSRC), .TX_BIT(tx_pos(MS_W))) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_vec), .tx_set(tx_set),
    .clr_we(clr_we), .clr_bits(clr_bits), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .raw_q(raw_q), .mask_q(mask_q)
  );

  uirq_router #(.MS_W(MS_W), .ERR_W(ERR_W), .NSRC(NSRC)) u_route (
    .clk(clk), .rst_n(rst_n), .raw_q(raw_q), .mask_q(mask_q), .irq_q(irq_out)
  );

  a_r4_raw_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && ev_vec == '0) |=> ($stable(raw_q) && $stable(mask_q)));

  a_r5_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((raw_q & $past(ev_vec)) == $past(ev_vec)));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ev_rx = 1'b0, ev_tx = 1'b0, ev_rt = 1'b0;
  logic [3:0]  ev_ms = '0, ev_err = '0;
  logic [5:0]  irq_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  logic [10:0] m_raw = '0, m_mask = '0;
  logic [5:0]  m_irq = '0;

  uart_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx(ev_rx),
    .ev_tx(ev_tx), .ev_rt(ev_rt), .ev_ms(ev_ms), .ev_err(ev_err),
    .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic [5:0] lines_of(logic [10:0] act);
    logic [5:0] l;
    l[1] = act[4];
    l[2] = act[5];
    l[3] = act[6];
    l[4] = |act[3:0];
    l[5] = |act[10:7];
    l[0] = act != 0;
    return l;
  endfunction

  always @(posedge clk) begin
    logic [10:0] setv, clrv;
    if (!rst_n) begin
      m_raw <= '0; m_mask <= '0; m_irq <= '0;
    end else begin
      setv = {ev_err, ev_rt, ev_tx, ev_rx, ev_ms};
      if (bus_wr && bus_addr == 3'd4) setv[5] = 1'b1;
      clrv = (bus_wr && bus_addr == 3'd3) ? bus_wdata[10:0] : '0;
      m_irq <= lines_of(m_raw & m_mask);
      m_raw <= (m_raw & ~clrv) | setv;
      if (bus_wr && bus_addr == 3'd0) m_mask <= bus_wdata[10:0];
    end
  end

  // per-cycle output comparison (R8, R9, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 6; i++) begin
        checks++;
        if (irq_out[i] !== m_irq[i]) begin
          errors++;
          if (i == 0) $display("FAIL R8 R10 line 0 actual %b expected %b", irq_out[i], m_irq[i]);
          else        $display("FAIL R9 R10 line %0d actual %b expected %b", i, irq_out[i], m_irq[i]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic wr, input logic [2:0] a, input logic [15:0] d,
                      input logic [10:0] ev);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    {ev_err, ev_rt, ev_tx, ev_rx, ev_ms} = ev;
    @(negedge clk);
    bus_wr = 1'b0;
    {ev_err, ev_rt, ev_tx, ev_rx, ev_ms} = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    bus_wr = 1'b0; bus_addr = a;
    {ev_err, ev_rt, ev_tx, ev_rx, ev_ms} = '0;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", req, a, bus_rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({10'd0, irq_out}, 16'h0, "R1 outputs");
    rd_chk(3'd0, 16'h0, "R1 mask");
    rd_chk(3'd1, 16'h0, "R1 raw");

    // R2 mask write/read, R5 event, R10 delay
    step(1'b1, 3'd0, 16'hFFFF, '0);
    rd_chk(3'd0, 16'h07FF, "R2 mask read");
    step(1'b0, 3'd0, 16'h0, 11'h010);            // rx event
    chk({15'd0, irq_out[1]}, 16'h0, "R10 rx not yet");
    rd_chk(3'd1, 16'h0010, "R5 raw rx");
    chk({15'd0, irq_out[1]}, 16'h1, "R10 rx after one cycle");
    chk({15'd0, irq_out[0]}, 16'h1, "R8 combined");

    // R5 each group
    step(1'b0, 3'd0, 16'h0, 11'h781);
    step(1'b0, 3'd0, 16'h0, 11'h040);
    rd_chk(3'd1, 16'h07D1, "R5 raw groups");

    // R2 masked read with partial mask
    step(1'b1, 3'd0, 16'h0009, '0);
    rd_chk(3'd2, 16'h0001, "R2 masked read");
    @(negedge clk);
    chk({10'd0, irq_out}, 16'h0011, "R9 modem only");

    // R4 writes to status addresses ignored
    step(1'b1, 3'd1, 16'h0000, '0);
    step(1'b1, 3'd2, 16'hFFFF, '0);
    rd_chk(3'd1, 16'h07D1, "R4 raw kept");
    rd_chk(3'd0, 16'h0009, "R4 mask kept");

    // R3 clear
    step(1'b1, 3'd3, 16'h0011, '0);
    rd_chk(3'd1, 16'h07C0, "R3 partial clear");
    rd_chk(3'd3, 16'h0, "R3 clear reads zero");
    @(negedge clk);
    chk({10'd0, irq_out}, 16'h0, "R9 masked off");

    // R6 tx write
    step(1'b1, 3'd4, 16'h0000, '0);
    rd_chk(3'd1, 16'h07E0, "R6 tx set");
    step(1'b1, 3'd0, 16'h0020, '0);
    @(negedge clk);
    chk({10'd0, irq_out}, 16'h0005, "R9 tx line");

    // R7 set wins
    step(1'b1, 3'd3, 16'h07FF, 11'h080);
    rd_chk(3'd1, 16'h0080, "R7 set wins");

    // error group line
    step(1'b1, 3'd0, 16'h0780, '0);
    @(negedge clk);
    chk({10'd0, irq_out}, 16'h0021, "R9 error line");
    step(1'b0, 3'd0, 16'h0, 11'h040);
    step(1'b1, 3'd0, 16'h0040, '0);
    @(negedge clk);
    chk({10'd0, irq_out}, 16'h0009, "R9 timeout line");

    // R11 unused reads
    rd_chk(3'd4, 16'h0, "R11 addr4");
    rd_chk(3'd5, 16'h0, "R11 addr5");
    rd_chk(3'd6, 16'h0, "R11 addr6");
    rd_chk(3'd7, 16'h0, "R11 addr7");

    // mixed pattern
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[3:1], {lf[7:0], lf[15:8]}, (lf[4] ? lf[14:4] : 11'h0));
      if (k % 10 == 0) begin
        rd_chk(3'd1, {5'd0, m_raw}, "R5 raw mixed");
        rd_chk(3'd2, {5'd0, m_raw & m_mask}, "R2 masked mixed");
      end
    end

    // reset again
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({10'd0, irq_out}, 16'h0, "R1 outputs after reset");
    rst_n = 1'b1;
    rd_chk(3'd1, 16'h0, "R1 raw after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule